// File: doc/BRIEF.md
# Keyed watchdog timer

A memory-mapped watchdog that counts ticks from one of four tick-enable inputs. When the count reaches a programmed limit, it sets a sticky timeout flag and pulses a reset request for one bus clock. The counter address also acts as a command port. Writing a two-word restart key to it clears the count. Writing a different two-word opening key grants a short interval in which the configuration registers accept writes.

Firmware arms the block by opening configuration, programming the limit, the window and the tick source, and then writing the control byte with the run bit set. The control byte also carries a "reconfigurable" bit. If software clears it when enabling, every later opening key is refused until the next reset. This lets a very short limit be locked in so that a system reset is forced. If a non-zero window is programmed, a restart that arrives while the count is still below the window is treated as a timeout.

Top module: `keyed_wdt`

## Requirements
- R1: Register layout (byte offsets):
  - Offset 0: byte 0 holds run (bit 7) and reconfigurable (bit 5); byte 1 holds tick source (bits 9:8) and timeout flag (bit 14).
  - Offsets 4, 8 and 12 are the count, limit and window words.
  - Reset values: run 0, reconfigurable 1, source 0, flag 0, count 0, limit 0x1500, window 0.
- R2: Writing 0x0000A602 to offset 4 and then 0x0000B480 to offset 4 clears the count on the edge of the second write.
- R3: A key sequence is dropped if any other value is written to offset 4 between the two words. It is also dropped if the second word arrives more than 16 bus clocks after the first. A gap of exactly 16 clocks is still accepted.
- R4: Writes to the control byte, the source field, the limit and the window are ignored unless configuration is open. Writing 0x0000C520 and then 0x0000D928 to offset 4 opens it, under the same abort rules as R3. It stays open for 128 bus clocks, or until byte 0 of offset 0 is written, whichever comes first.
- R5: While run is set, the count rises by one on each bus clock where tick_i[source] is high. The other tick inputs are ignored. While run is clear the count holds.
- R6: A tick that brings the count to the limit sets the flag, drives rst_req_o high for exactly one clock and restarts the count at 0. No request is raised while run is clear.
- R7: Writing 1 to bit 14 at offset 0 (strobe 1) clears the flag, whether configuration is open or not. Writing 0 to that bit has no effect.
- R8: After the control byte is written with reconfigurable = 0, the opening key no longer opens configuration until reset.
- R9: With a non-zero window, a restart key completed while count < window acts as a timeout, as in R6. A count equal to or above the window restarts normally. A window of 0 disables the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte offset of the word accessed |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte strobes |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| tick_i | input | 4 | Tick enables: bus, low-power, 32 kHz, external |
| rst_req_o | output | 1 | One-clock reset request |
| flag_o | output | 1 | Sticky timeout flag |

## Verification
The assertions check on every cycle the following:
- A reset request always coincides with a set flag.
- No request appears while run is clear.
- A completed restart key leaves the count at zero.
- The count holds while stopped.
- The limit and window stay unchanged whenever configuration is closed.
- Configuration can never be open once the reconfigurable bit is clear.

Only the bench scenarios can show the following:
- The exact key gap boundary.
- Interleaved and aborted key streams.
- The length of the open interval.
- The window violation.
- A locked short forced timeout.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DW   = 32;
  localparam int AW   = 4;
  localparam int NB   = DW / 8;
  localparam int NSRC = 4;
  localparam int SW   = $clog2(NSRC);

  localparam logic [DW-1:0] RESTART_K0 = 32'h0000_A602;
  localparam logic [DW-1:0] RESTART_K1 = 32'h0000_B480;
  localparam logic [DW-1:0] OPEN_K0    = 32'h0000_C520;
  localparam logic [DW-1:0] OPEN_K1    = 32'h0000_D928;

  localparam logic [AW-1:0] OFF_CTRL  = 4'h0;
  localparam logic [AW-1:0] OFF_CNT   = 4'h4;
  localparam logic [AW-1:0] OFF_LIMIT = 4'h8;
  localparam logic [AW-1:0] OFF_WIN   = 4'hC;

  localparam int RUN_BIT  = 7;
  localparam int RCFG_BIT = 5;
  localparam int SRC_LSB  = 8;
  localparam int FLAG_BIT = 14;

  typedef struct packed {
    logic          run;
    logic          rcfg;
    logic [SW-1:0] src;
    logic [DW-1:0] limit;
    logic [DW-1:0] win;
  } cfg_t;
endpackage

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq #(
  parameter logic [31:0] KEY0 = 32'h0,
  parameter logic [31:0] KEY1 = 32'h1,
  parameter int          GAP  = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] data_i,
  output logic        hit_o
);
  localparam int GW = $clog2(GAP + 1);

  logic          armed_q;
  logic [GW-1:0] gap_q;

  assign hit_o = wr_i && armed_q && (data_i == KEY1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else if (wr_i) begin
      if (hit_o) begin
        armed_q <= 1'b0;
      end else if (data_i == KEY0) begin
        armed_q <= 1'b1;
        gap_q   <= GW'(1);
      end else begin
        armed_q <= 1'b0;
      end
    end else if (armed_q) begin
      // second word may land at most GAP clocks after the first
      if (gap_q == GW'(GAP)) armed_q <= 1'b0;
      else                   gap_q   <= gap_q + GW'(1);
    end
  end
endmodule

// File: rtl/kwdt_cfg.sv
module kwdt_cfg
  import kwdt_pkg::*;
#(
  parameter logic [DW-1:0] LIMIT_RST = 32'h0000_1500,
  parameter int            OPEN_CYC  = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NB-1:0] be_i,
  input  logic          open_key_i,
  input  logic          flag_set_i,
  output cfg_t          cfg_o,
  output logic          open_o,
  output logic          flag_o
);
  localparam int OW = $clog2(OPEN_CYC);

  logic          run_q, rcfg_q, flag_q, open_q;
  logic [SW-1:0] src_q;
  logic [DW-1:0] limit_q, win_q;
  logic [OW-1:0] open_cnt_q;
  logic          wr_ctrl, wr_limit, wr_win;

  assign wr_ctrl  = wr_i && (addr_i == OFF_CTRL);
  assign wr_limit = wr_i && (addr_i == OFF_LIMIT);
  assign wr_win   = wr_i && (addr_i == OFF_WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q     <= 1'b0;
      open_cnt_q <= '0;
    end else if (open_key_i && rcfg_q) begin
      open_q     <= 1'b1;
      open_cnt_q <= '0;
    end else if (open_q) begin
      if ((wr_ctrl && be_i[0]) || (open_cnt_q == OW'(OPEN_CYC - 1))) open_q <= 1'b0;
      else open_cnt_q <= open_cnt_q + OW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      rcfg_q  <= 1'b1;
      src_q   <= '0;
      limit_q <= LIMIT_RST;
      win_q   <= '0;
    end else if (open_q) begin
      if (wr_ctrl && be_i[0]) begin
        run_q  <= wdata_i[RUN_BIT];
        rcfg_q <= wdata_i[RCFG_BIT];
      end
      if (wr_ctrl && be_i[1]) src_q <= wdata_i[SRC_LSB +: SW];
      for (int b = 0; b < NB; b++) begin
        if (wr_limit && be_i[b]) limit_q[8*b +: 8] <= wdata_i[8*b +: 8];
        if (wr_win && be_i[b])   win_q[8*b +: 8]   <= wdata_i[8*b +: 8];
      end
    end
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           flag_q <= 1'b0;
    else if (flag_set_i)                                   flag_q <= 1'b1;
    else if (wr_ctrl && be_i[1] && wdata_i[FLAG_BIT])      flag_q <= 1'b0;
  end

  assign cfg_o  = '{run: run_q, rcfg: rcfg_q, src: src_q, limit: limit_q, win: win_q};
  assign open_o = open_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [SW-1:0]   src_i,
  input  logic [DW-1:0]   limit_i,
  input  logic [DW-1:0]   win_i,
  input  logic [NSRC-1:0] tick_i,
  input  logic            restart_i,
  output logic [DW-1:0]   cnt_o,
  output logic            evt_o,
  output logic            req_o
);
  logic [DW-1:0] cnt_q;
  logic          req_q, tick, expire, early;

  assign tick   = run_i && tick_i[src_i];
  assign expire = tick && !restart_i && (({1'b0, cnt_q} + 33'd1) >= {1'b0, limit_i});
  assign early  = restart_i && run_i && (win_i != '0) && (cnt_q < win_i);
  assign evt_o  = expire || early;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= evt_o;
      if (restart_i || evt_o) cnt_q <= '0;
      else if (tick)          cnt_q <= cnt_q + DW'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter logic [31:0] LIMIT_RST = 32'h0000_1500,
  parameter int          KEY_GAP   = 16,
  parameter int          OPEN_CYC  = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic [3:0]  be_i,
  output logic [31:0] rdata_o,
  input  logic [3:0]  tick_i,
  output logic        rst_req_o,
  output logic        flag_o
);
  cfg_t          cfg_q;
  logic          cfg_open, cnt_wr, evt;
  logic [1:0]    key_hit;
  logic          restart_hit, open_hit;
  logic [DW-1:0] cnt;

  assign cnt_wr = wr_i && (addr_i == OFF_CNT);

  // index 0: restart key, index 1: opening key
  for (genvar g = 0; g < 2; g++) begin : g_key
    kwdt_key_seq #(
      .KEY0 (g == 0 ? RESTART_K0 : OPEN_K0),
      .KEY1 (g == 0 ? RESTART_K1 : OPEN_K1),
      .GAP  (KEY_GAP)
    ) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (cnt_wr),
      .data_i (wdata_i),
      .hit_o  (key_hit[g])
    );
  end
  assign restart_hit = key_hit[0];
  assign open_hit    = key_hit[1];

  kwdt_cfg #(.LIMIT_RST(LIMIT_RST), .OPEN_CYC(OPEN_CYC)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .be_i       (be_i),
    .open_key_i (open_hit),
    .flag_set_i (evt),
    .cfg_o      (cfg_q),
    .open_o     (cfg_open),
    .flag_o     (flag_o)
  );

  kwdt_counter u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (cfg_q.run),
    .src_i     (cfg_q.src),
    .limit_i   (cfg_q.limit),
    .win_i     (cfg_q.win),
    .tick_i    (tick_i),
    .restart_i (restart_hit),
    .cnt_o     (cnt),
    .evt_o     (evt),
    .req_o     (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL: begin
        rdata_o[RUN_BIT]           = cfg_q.run;
        rdata_o[RCFG_BIT]          = cfg_q.rcfg;
        rdata_o[SRC_LSB +: SW]     = cfg_q.src;
        rdata_o[FLAG_BIT]          = flag_o;
      end
      OFF_CNT:   rdata_o = cnt;
      OFF_LIMIT: rdata_o = cfg_q.limit;
      OFF_WIN:   rdata_o = cfg_q.win;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        flag_i,
  input logic        run_i,
  input logic        rcfg_i,
  input logic        open_i,
  input logic        restart_i,
  input logic [31:0] cnt_i,
  input logic [31:0] limit_i,
  input logic [31:0] win_i
);
  AST_REQ_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> flag_i); // R6
  AST_NO_REQ_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !req_i); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_i == 32'd0)); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(cnt_i)); // R5
  AST_CLOSED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> ($stable(limit_i) && $stable(win_i))); // R4
  AST_LOCK_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rcfg_i |-> !open_i); // R8
endmodule

bind keyed_wdt kwdt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (rst_req_o),
  .flag_i    (flag_o),
  .run_i     (cfg_q.run),
  .rcfg_i    (cfg_q.rcfg),
  .open_i    (cfg_open),
  .restart_i (restart_hit),
  .cnt_i     (cnt),
  .limit_i   (cfg_q.limit),
  .win_i     (cfg_q.win)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic [3:0]  be = 4'h0;
  logic [3:0]  tick = 4'h0;
  logic [31:0] rdata;
  logic        req, flag;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] v;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyed_wdt u_keyed_wdt (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .be_i(be), .rdata_o(rdata), .tick_i(tick), .rst_req_o(req), .flag_o(flag)
  );

  function automatic logic [31:0] ctrl_word(bit run, bit rcfg, logic [1:0] src, bit flg);
    ctrl_word = 32'h0;
    ctrl_word[7] = run;
    ctrl_word[5] = rcfg;
    ctrl_word[9:8] = src;
    ctrl_word[14] = flg;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr32(logic [3:0] a, logic [31:0] d, logic [3:0] b);
    addr = a; wdata = d; be = b; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = 4'h0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(int idx, int n);
    for (int i = 0; i < n; i++) begin
      tick[idx] = 1'b1;
      @(negedge clk);
      tick[idx] = 1'b0;
    end
  endtask

  task automatic open_cfg();
    wr32(4'h4, 32'h0000_C520, 4'hF);
    wr32(4'h4, 32'h0000_D928, 4'hF);
  endtask

  task automatic restart();
    wr32(4'h4, 32'h0000_A602, 4'hF);
    wr32(4'h4, 32'h0000_B480, 4'hF);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired before the sequence ended");
    summary();
    $finish;
  end

  initial begin
    bit armed;
    int t_arm, exp_cnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl reset", v, ctrl_word(0, 1, 2'd0, 0));
    rd(4'h4, v); chk("R1 count reset", v, 32'h0);
    rd(4'h8, v); chk("R1 limit reset", v, 32'h0000_1500);
    rd(4'hC, v); chk("R1 window reset", v, 32'h0);
    chk("R1 req reset", {31'h0, req}, 32'h0);

    // R4 locked write ignored
    wr32(4'h8, 32'h5, 4'hF);
    rd(4'h8, v); chk("R4 locked limit", v, 32'h0000_1500);

    // R4 open, program, close on control write
    open_cfg();
    wr32(4'h8, 32'd10, 4'hF);
    wr32(4'h0, ctrl_word(1, 1, 2'd1, 0), 4'h3);
    rd(4'h0, v); chk("R4 ctrl programmed", v, ctrl_word(1, 1, 2'd1, 0));
    wr32(4'h8, 32'd99, 4'hF);
    rd(4'h8, v); chk("R4 closed by ctrl write", v, 32'd10);

    // R5 unselected source ignored, selected counts
    pulse(2, 3);
    rd(4'h4, v); chk("R5 other tick ignored", v, 32'd0);
    pulse(1, 9);
    rd(4'h4, v); chk("R5 count", v, 32'd9);
    chk("R6 no req early", {31'h0, req}, 32'h0);
    pulse(1, 1);
    chk("R6 req at limit", {31'h0, req}, 32'h1);
    chk("R6 flag at limit", {31'h0, flag}, 32'h1);
    rd(4'h4, v); chk("R6 count restarts", v, 32'd0);
    @(negedge clk);
    chk("R6 req one clock", {31'h0, req}, 32'h0);

    // R7 flag write-0 no effect, write-1 clears; source locked
    wr32(4'h0, 32'h0, 4'h2);
    chk("R7 write 0 keeps flag", {31'h0, flag}, 32'h1);
    wr32(4'h0, 32'h0000_4000, 4'h2);
    rd(4'h0, v); chk("R7 flag cleared, src kept", v, ctrl_word(1, 1, 2'd1, 0));

    // R2/R3 gap boundaries
    pulse(1, 4);
    wr32(4'h4, 32'h0000_A602, 4'hF); idle(15); wr32(4'h4, 32'h0000_B480, 4'hF);
    rd(4'h4, v); chk("R3 gap 16 accepted", v, 32'd0);
    pulse(1, 4);
    wr32(4'h4, 32'h0000_A602, 4'hF); idle(16); wr32(4'h4, 32'h0000_B480, 4'hF);
    rd(4'h4, v); chk("R3 gap 17 rejected", v, 32'd4);
    wr32(4'h4, 32'h0000_A602, 4'hF); wr32(4'h4, 32'h0001_1234, 4'hF);
    wr32(4'h4, 32'h0000_B480, 4'hF);
    rd(4'h4, v); chk("R3 interleaved value aborts", v, 32'd4);
    restart();
    rd(4'h4, v); chk("R2 restart clears", v, 32'd0);

    // random key stream on the external tick source
    open_cfg();
    wr32(4'h8, 32'd1000000, 4'hF);
    wr32(4'hC, 32'd0, 4'hF);
    wr32(4'h0, ctrl_word(1, 1, 2'd3, 0), 4'h3);
    rd(4'h0, v); chk("R4 ctrl ext source", v, ctrl_word(1, 1, 2'd3, 0));
    armed = 1'b0; t_arm = 0; exp_cnt = 0;
    for (int i = 0; i < 200; i++) begin
      int n, sel, t, k;
      logic [31:0] d;
      n = ($urandom_range(0, 3) == 0) ? int'($urandom_range(14, 20)) : int'($urandom_range(0, 3));
      for (int j = 0; j < n; j++) begin
        bit tk;
        tk = 1'($urandom_range(0, 1));
        tick[3] = tk;
        @(negedge clk);
        tick[3] = 1'b0;
        exp_cnt += int'(tk);
      end
      sel = $urandom_range(0, 5);
      case (sel)
        0, 1: d = 32'h0000_A602;
        2, 3: d = 32'h0000_B480;
        4:    d = ($urandom_range(0, 1) == 0) ? 32'h0000_C520 : 32'h0000_D928;
        default: d = $urandom() | 32'h0001_0000;
      endcase
      t = cyc;
      k = t - t_arm;
      if (armed && d == 32'h0000_B480 && k <= 16) begin
        exp_cnt = 0; armed = 1'b0;
      end else if (d == 32'h0000_A602) begin
        armed = 1'b1; t_arm = t;
      end else begin
        armed = 1'b0;
      end
      wr32(4'h4, d, 4'hF);
      rd(4'h4, v); chk("R3 random key stream", v, 32'(exp_cnt));
    end
    restart();
    rd(4'h4, v); chk("R2 restart after stream", v, 32'd0);

    // R9 window
    open_cfg();
    wr32(4'hC, 32'd4, 4'hF);
    wr32(4'h8, 32'd50, 4'hF);
    wr32(4'h0, ctrl_word(1, 1, 2'd3, 0), 4'h3);
    pulse(3, 2);
    restart();
    chk("R9 early restart req", {31'h0, req}, 32'h1);
    chk("R9 early restart flag", {31'h0, flag}, 32'h1);
    wr32(4'h0, 32'h0000_4000, 4'h2);
    pulse(3, 5);
    restart();
    chk("R9 late restart no req", {31'h0, req}, 32'h0);
    pulse(3, 4);
    restart();
    chk("R9 restart at window no req", {31'h0, req}, 32'h0);
    chk("R9 flag stays clear", {31'h0, flag}, 32'h0);

    // R4 open interval length
    open_cfg(); idle(100); wr32(4'h8, 32'd33, 4'hF);
    rd(4'h8, v); chk("R4 write inside open interval", v, 32'd33);
    open_cfg(); idle(200); wr32(4'h8, 32'd44, 4'hF);
    rd(4'h8, v); chk("R4 write after interval", v, 32'd33);

    // R5 stopped counter
    open_cfg();
    wr32(4'h0, ctrl_word(0, 1, 2'd3, 0), 4'h3);
    pulse(3, 60);
    rd(4'h4, v); chk("R5 holds when stopped", v, 32'd0);
    chk("R6 no req when stopped", {31'h0, req}, 32'h0);

    // R8 permanent lock with short limit
    open_cfg();
    wr32(4'h8, 32'd5, 4'hF);
    wr32(4'h0, ctrl_word(1, 0, 2'd3, 0), 4'h3);
    open_cfg();
    wr32(4'h8, 32'd77, 4'hF);
    wr32(4'hC, 32'd9, 4'hF);
    rd(4'h8, v); chk("R8 limit locked", v, 32'd5);
    rd(4'hC, v); chk("R8 window locked", v, 32'd4);
    pulse(3, 4);
    chk("R8 no req before limit", {31'h0, req}, 32'h0);
    pulse(3, 1);
    chk("R8 forced timeout req", {31'h0, req}, 32'h1);

    summary();
    $finish;
  end
endmodule